// File: doc/BRIEF.md
# General-Purpose I/O Port with Direction Control

This block is an 8-bit register-mapped I/O port for a small microcontroller core. A register bus reaches two registers: the port register and the direction register. The six low bits of the port are pad pins. The two high bits carry the clock and data lines of a serial EEPROM peripheral. Each pad pin has an output latch and a direction bit. A direction bit of 1 turns the driver off and makes the pin an input. A direction bit of 0 drives the latch value onto the pin.

A port read returns the pin levels after a two-flop synchronizer, never the latch. Pins that the core hands to another function read as 0 and have their driver disabled. These functions are alternate, analog, oscillator and reset. Pin 3 is input-only. Pins 0, 1 and 3 form a fixed group that shares one weak pull-up enable and one change detector. The detector sets a sticky flag when a group pin no longer matches the level captured at the last port read.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction register reads 0x3F, with bits 7:6 always 0. All pad drivers are off, the pad latch is 0, the EEPROM line latch `ee_o` is 2'b11 and the change flag is 0.
- R2: The port register is at address 0x05 and the direction register at 0x85. Reads of any other address return 0x00, and writes to them change no state.
- R3: `pad_oe_o[i]` is 1 exactly when direction bit i is 0 and pin i has no other function. `pad_o` shows the output latch.
- R4: Read data appears the cycle after the read strobe. A port read returns {ee_i[1:0], pin levels[5:0]} after a two-flop synchronizer. When a driven pin is held at another level externally, the read shows the external level.
- R5: A port write updates the latch while the pin is an input. The value holds until the next port write and appears once the direction bit is cleared.
- R6: Pin 3 has no latch and no driver: `pad_o[3]` and `pad_oe_o[3]` stay 0, and direction bit 3 always reads 1.
- R7: A pin with `alt_i` or `ana_i` set reads as 0. `xosc_en_i` does the same for pins 5:4, and `mclr_en_i` for pin 3. Pins in any of these cases reads as 0 and have their driver off.
- R8: `pu_o` = 6'b001011 when `wpu_n_i` is 0, and 0 otherwise. With `mclr_en_i` set, `pu_o[3]` is 1 whatever `wpu_n_i` is. Bits 2, 4 and 5 are never set.
- R9: `chg_flag_o` sets when the read-masked level of pin 0, 1 or 3 differs from its value at the last port read. It rises on the third rising edge after a pad change. Other pins never set it. `irq_o` = `chg_flag_o` AND `ioc_en_i`.
- R10: The change flag is sticky. `chg_clr_i` clears it unless a mismatch is present in the same cycle, and a mismatch wins.
- R11: With `mclr_en_i` set, pin 3 does not take part in change detection.
- R12: A port write loads `wdata_i[7:6]` into `ee_o[1:0]`. Nothing else changes `ee_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_i` |
| pad_i | input | 6 | Pad pin levels |
| pad_o | output | 6 | Pad output values |
| pad_oe_o | output | 6 | Pad driver enables |
| pu_o | output | 6 | Weak pull-up enables |
| ee_i | input | 2 | EEPROM clock/data line levels |
| ee_o | output | 2 | EEPROM clock/data line latch |
| alt_i | input | 6 | Pins taken by an alternate function |
| ana_i | input | 6 | Pins in analog mode |
| xosc_en_i | input | 1 | External oscillator owns pins 5:4 |
| mclr_en_i | input | 1 | Pin 3 is the reset input |
| wpu_n_i | input | 1 | Group pull-up enable, active low |
| ioc_en_i | input | 1 | Change interrupt enable |
| chg_clr_i | input | 1 | Clear the change flag |
| chg_flag_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Change interrupt |

## Verification
Register writes take effect on the write edge, so `pad_o`, `pad_oe_o` and `ee_o` are sampled at the falling edge that follows. Read data is checked at the falling edge after the read edge: the bench registers its own read strobe, and a monitor pops the queued expected value at that point. A pad change reaches the read path after two rising edges and the change flag after three. The bench waits three falling edges after each pad change before it reads or checks the flag. Function masks, pull-ups and `irq_o` are combinational, and the bench checks them one falling edge after each input change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned GP_NPIN = 6;
  localparam int unsigned GP_NEE  = 2;
  localparam int unsigned GP_DW   = GP_NPIN + GP_NEE;
  localparam int unsigned GP_AW   = 8;
  localparam int unsigned GP_SYNC = 2;

  localparam logic [GP_AW-1:0] GP_PORT_ADDR = 8'h05;
  localparam logic [GP_AW-1:0] GP_DIR_ADDR  = 8'h85;

  localparam int unsigned GP_INONLY = 3;
  localparam logic [GP_NPIN-1:0] GP_INONLY_BIT = 6'b001000;
  localparam logic [GP_NPIN-1:0] GP_GRP_MASK   = 6'b001011;
  localparam logic [GP_NPIN-1:0] GP_OSC_MASK   = 6'b110000;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PORT,
    SEL_DIR
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_fnmask.sv
module gpio_fnmask
  import gpio_pkg::*;
(
  input  logic [GP_NPIN-1:0] alt_i,
  input  logic [GP_NPIN-1:0] ana_i,
  input  logic               xosc_en_i,
  input  logic               mclr_en_i,
  output logic [GP_NPIN-1:0] mask_o
);
  for (genvar i = 0; i < GP_NPIN; i++) begin : g_pin
    if (GP_OSC_MASK[i]) begin : g_osc
      assign mask_o[i] = alt_i[i] | ana_i[i] | xosc_en_i;
    end else if (GP_INONLY_BIT[i]) begin : g_rst
      assign mask_o[i] = alt_i[i] | ana_i[i] | mclr_en_i;
    end else begin : g_plain
      assign mask_o[i] = alt_i[i] | ana_i[i];
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter logic [GP_AW-1:0] PORT_ADDR = GP_PORT_ADDR,
  parameter logic [GP_AW-1:0] DIR_ADDR  = GP_DIR_ADDR
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [GP_AW-1:0]   addr_i,
  input  logic [GP_DW-1:0]   wdata_i,
  input  logic [GP_NPIN-1:0] pin_lvl_i,
  input  logic [GP_NEE-1:0]  ee_lvl_i,
  output logic [GP_DW-1:0]   rdata_o,
  output logic [GP_NPIN-1:0] lat_o,
  output logic [GP_NPIN-1:0] dir_o,
  output logic [GP_NEE-1:0]  ee_lat_o,
  output logic               port_rd_o
);
  reg_sel_e sel;
  logic [GP_NPIN-1:0] lat_q, dir_q;
  logic [GP_NEE-1:0]  ee_q;
  logic [GP_DW-1:0]   rdata_q;

  always_comb begin
    sel = SEL_NONE;
    if (addr_i == PORT_ADDR)     sel = SEL_PORT;
    else if (addr_i == DIR_ADDR) sel = SEL_DIR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      dir_q <= '1;
      ee_q  <= '1;
    end else if (wr_i) begin
      unique case (sel)
        SEL_PORT: begin
          lat_q <= wdata_i[GP_NPIN-1:0] & ~GP_INONLY_BIT;
          ee_q  <= wdata_i[GP_NPIN +: GP_NEE];
        end
        SEL_DIR:  dir_q <= wdata_i[GP_NPIN-1:0] | GP_INONLY_BIT;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      unique case (sel)
        SEL_PORT: rdata_q <= {ee_lvl_i, pin_lvl_i};
        SEL_DIR:  rdata_q <= {{GP_NEE{1'b0}}, dir_q};
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o   = rdata_q;
  assign lat_o     = lat_q;
  assign dir_o     = dir_q;
  assign ee_lat_o  = ee_q;
  assign port_rd_o = rd_i && (sel == SEL_PORT);
endmodule

// File: rtl/gpio_ioc.sv
module gpio_ioc
  import gpio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GP_NPIN-1:0] pin_lvl_i,
  input  logic               port_rd_i,
  input  logic               chg_clr_i,
  input  logic               mclr_en_i,
  input  logic               wpu_n_i,
  output logic               flag_o,
  output logic [GP_NPIN-1:0] pu_o
);
  logic [GP_NPIN-1:0] grp, snap_q;
  logic               diff, flag_q;

  // reset-pin use removes pin 3 from the watched group
  assign grp  = GP_GRP_MASK & ~({GP_NPIN{mclr_en_i}} & GP_INONLY_BIT);
  assign diff = |((pin_lvl_i ^ snap_q) & grp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (port_rd_i) snap_q <= pin_lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (diff)      flag_q <= 1'b1;
    else if (chg_clr_i) flag_q <= 1'b0;
  end

  for (genvar i = 0; i < GP_NPIN; i++) begin : g_pu
    if (GP_INONLY_BIT[i]) begin : g_rst
      assign pu_o[i] = !wpu_n_i || mclr_en_i;
    end else if (GP_GRP_MASK[i]) begin : g_grp
      assign pu_o[i] = !wpu_n_i;
    end else begin : g_none
      assign pu_o[i] = 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter logic [GP_AW-1:0] PORT_ADDR   = GP_PORT_ADDR,
  parameter logic [GP_AW-1:0] DIR_ADDR    = GP_DIR_ADDR,
  parameter int unsigned      SYNC_STAGES = GP_SYNC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [GP_AW-1:0]   addr_i,
  input  logic [GP_DW-1:0]   wdata_i,
  output logic [GP_DW-1:0]   rdata_o,
  input  logic [GP_NPIN-1:0] pad_i,
  output logic [GP_NPIN-1:0] pad_o,
  output logic [GP_NPIN-1:0] pad_oe_o,
  output logic [GP_NPIN-1:0] pu_o,
  input  logic [GP_NEE-1:0]  ee_i,
  output logic [GP_NEE-1:0]  ee_o,
  input  logic [GP_NPIN-1:0] alt_i,
  input  logic [GP_NPIN-1:0] ana_i,
  input  logic               xosc_en_i,
  input  logic               mclr_en_i,
  input  logic               wpu_n_i,
  input  logic               ioc_en_i,
  input  logic               chg_clr_i,
  output logic               chg_flag_o,
  output logic               irq_o
);
  logic [GP_DW-1:0]   sync_lvl;
  logic [GP_NPIN-1:0] fn_mask, pin_lvl, lat, dir;
  logic               port_rd, flag;

  gpio_sync #(.W(GP_DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ee_i, pad_i}),
    .q_o   (sync_lvl)
  );

  gpio_fnmask u_fnmask (
    .alt_i    (alt_i),
    .ana_i    (ana_i),
    .xosc_en_i(xosc_en_i),
    .mclr_en_i(mclr_en_i),
    .mask_o   (fn_mask)
  );

  assign pin_lvl = sync_lvl[GP_NPIN-1:0] & ~fn_mask;

  gpio_regs #(.PORT_ADDR(PORT_ADDR), .DIR_ADDR(DIR_ADDR)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .pin_lvl_i(pin_lvl),
    .ee_lvl_i (sync_lvl[GP_NPIN +: GP_NEE]),
    .rdata_o  (rdata_o),
    .lat_o    (lat),
    .dir_o    (dir),
    .ee_lat_o (ee_o),
    .port_rd_o(port_rd)
  );

  gpio_ioc u_ioc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_lvl_i(pin_lvl),
    .port_rd_i(port_rd),
    .chg_clr_i(chg_clr_i),
    .mclr_en_i(mclr_en_i),
    .wpu_n_i  (wpu_n_i),
    .flag_o   (flag),
    .pu_o     (pu_o)
  );

  assign pad_o      = lat;
  assign pad_oe_o   = ~dir & ~fn_mask;
  assign chg_flag_o = flag;
  assign irq_o      = flag & ioc_en_i;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic               rd_i,
  input logic [GP_AW-1:0]   addr_i,
  input logic [GP_DW-1:0]   rdata_o,
  input logic [GP_NPIN-1:0] pad_oe_o,
  input logic [GP_NPIN-1:0] pu_o,
  input logic [GP_NEE-1:0]  ee_o,
  input logic [GP_NPIN-1:0] alt_i,
  input logic [GP_NPIN-1:0] ana_i,
  input logic               xosc_en_i,
  input logic               ioc_en_i,
  input logic               chg_clr_i,
  input logic               chg_flag_o,
  input logic               irq_o
);
  // R6
  gp3_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pad_oe_o[GP_INONLY]);

  // R7
  fn_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & (alt_i | ana_i | ({GP_NPIN{xosc_en_i}} & GP_OSC_MASK))) == '0);

  // R8
  pu_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_o & ~GP_GRP_MASK) == '0);

  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (chg_flag_o && ioc_en_i));

  // R10
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_flag_o && !chg_clr_i) |=> chg_flag_o);

  // R12
  ee_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ee_o));

  // R6
  dir_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == GP_DIR_ADDR) |=> (rdata_o[GP_INONLY] && rdata_o[GP_DW-1 -: GP_NEE] == '0));

  // R2
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != GP_DIR_ADDR && addr_i != GP_PORT_ADDR) |=> rdata_o == '0);
endmodule

bind gpio_port gpio_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .pad_oe_o  (pad_oe_o),
  .pu_o      (pu_o),
  .ee_o      (ee_o),
  .alt_i     (alt_i),
  .ana_i     (ana_i),
  .xosc_en_i (xosc_en_i),
  .ioc_en_i  (ioc_en_i),
  .chg_clr_i (chg_clr_i),
  .chg_flag_o(chg_flag_o),
  .irq_o     (irq_o)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic [5:0] pad_in = '0, pad_out, pad_oe, pu;
  logic [1:0] ee_in = 2'b11, ee_out;
  logic [5:0] alt = '0, ana = '0;
  logic       xosc = 1'b0, mclr = 1'b0, wpu_n = 1'b1, ioc_en = 1'b0, clr = 1'b0;
  logic       flag, irq;

  int n_chk = 0;
  int n_fail = 0;
  logic rd_q = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out),
    .pad_oe_o(pad_oe), .pu_o(pu), .ee_i(ee_in), .ee_o(ee_out),
    .alt_i(alt), .ana_i(ana), .xosc_en_i(xosc), .mclr_en_i(mclr),
    .wpu_n_i(wpu_n), .ioc_en_i(ioc_en), .chg_clr_i(clr),
    .chg_flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // scoreboard monitor: read data due the falling edge after the read edge
  always @(posedge clk) rd_q <= rd;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: actual %02h expected none", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, rdata, e);
      end
    end
  end

  task automatic rd_exp(input logic [7:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    rd = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    // R1 reset state
    chk("R1 oe", {2'b0, pad_oe}, 8'h00);
    chk("R1 latch", {2'b0, pad_out}, 8'h00);
    chk("R1 ee latch", {6'b0, ee_out}, 8'h03);
    chk("R1 flag", {7'b0, flag}, 8'h00);
    chk("R8 pu off", {2'b0, pu}, 8'h00);
    rd_exp(8'h85, 8'h3F, "R1 dir");
    rd_exp(8'h05, 8'hC0, "R4 ee bits");

    // R2 unmapped address
    wr_reg(8'h10, 8'h55);
    rd_exp(8'h10, 8'h00, "R2 unmapped read");
    chk("R2 latch untouched", {2'b0, pad_out}, 8'h00);

    // R5 / R6 latch while input, pin 3 has no latch
    wr_reg(8'h05, 8'h2A);
    chk("R6 no pin3 latch", {2'b0, pad_out}, 8'h22);
    chk("R5 still input", {2'b0, pad_oe}, 8'h00);
    wr_reg(8'h85, 8'h00);
    rd_exp(8'h85, 8'h08, "R6 dir bit3");
    chk("R3 oe", {2'b0, pad_oe}, 8'h37);
    chk("R5 latch held", {2'b0, pad_out}, 8'h22);

    // R4 contention: pins read low while latch drives high
    rd_exp(8'h05, 8'hC0, "R4 contention");

    // R9 / R10 change detection
    pad_in = 6'h2D; ee_in = 2'b01;
    wait_n(3);
    chk("R9 flag set", {7'b0, flag}, 8'h01);
    chk("R9 irq gated", {7'b0, irq}, 8'h00);
    ioc_en = 1'b1;
    wait_n(1);
    chk("R9 irq", {7'b0, irq}, 8'h01);
    wait_n(2);
    chk("R10 sticky", {7'b0, flag}, 8'h01);
    rd_exp(8'h05, 8'h6D, "R4 pin levels");
    clear_flag();
    chk("R10 cleared", {7'b0, flag}, 8'h00);
    pad_in = 6'h29;
    wait_n(3);
    chk("R9 non-group pin", {7'b0, flag}, 8'h00);
    rd_exp(8'h05, 8'h69, "R4 pin2 low");

    // R7 function masks
    ana = 6'h17;
    wait_n(1);
    chk("R7 analog oe", {2'b0, pad_oe}, 8'h20);
    rd_exp(8'h05, 8'h68, "R7 analog read");
    clear_flag();
    chk("R10 clear after resync", {7'b0, flag}, 8'h00);
    ana = 6'h00; alt = 6'h04;
    wait_n(1);
    chk("R7 alt oe", {2'b0, pad_oe}, 8'h33);
    xosc = 1'b1;
    wait_n(1);
    chk("R7 osc oe", {2'b0, pad_oe}, 8'h03);
    rd_exp(8'h05, 8'h49, "R7 osc read");
    clear_flag();
    chk("R10 clear", {7'b0, flag}, 8'h00);

    // R8 / R11 reset-pin mode
    alt = 6'h00; xosc = 1'b0; mclr = 1'b1;
    wait_n(1);
    chk("R8 pu forced", {2'b0, pu}, 8'h08);
    rd_exp(8'h05, 8'h61, "R7 reset pin read");
    wait_n(3);
    chk("R11 no flag", {7'b0, flag}, 8'h00);
    pad_in = 6'h21;
    wait_n(3);
    chk("R11 pin3 fall ignored", {7'b0, flag}, 8'h00);
    pad_in = 6'h29;
    wait_n(3);
    chk("R11 pin3 rise ignored", {7'b0, flag}, 8'h00);
    wpu_n = 1'b0;
    wait_n(1);
    chk("R8 pu group", {2'b0, pu}, 8'h0B);
    mclr = 1'b0;
    wait_n(3);
    chk("R9 pin3 in group", {7'b0, flag}, 8'h01);
    chk("R8 pu group no mclr", {2'b0, pu}, 8'h0B);
    rd_exp(8'h05, 8'h69, "R4 read");
    clear_flag();
    wpu_n = 1'b1;
    wait_n(1);
    chk("R8 pu disabled", {2'b0, pu}, 8'h00);

    // R12 EEPROM lines, R3 latch value
    wr_reg(8'h05, 8'h91);
    chk("R3 pad_o", {2'b0, pad_out}, 8'h11);
    chk("R12 ee latch", {6'b0, ee_out}, 8'h02);
    rd_exp(8'h05, 8'h69, "R4 not latch");
    chk("R12 ee held", {6'b0, ee_out}, 8'h02);

    // R1 / R2 / R3 direction back to inputs
    wr_reg(8'h85, 8'hFF);
    rd_exp(8'h85, 8'h3F, "R1 dir upper bits");
    chk("R3 oe off", {2'b0, pad_oe}, 8'h00);
    wr_reg(8'h86, 8'h00);
    rd_exp(8'h85, 8'h3F, "R2 neighbour write");
    chk("R2 oe unchanged", {2'b0, pad_oe}, 8'h00);

    wait_n(2);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule